// File: doc/BRIEF.md
# Storage Controller Enable and Shutdown Control Registers

This block holds the host-visible configuration and status registers that bring a storage host controller up and down. The host writes a configuration word that carries an enable bit and a two-bit shutdown request field. The block stores that word first. It then compares the new word with the old one and runs the matching actions against the controller core. A shutdown request edge comes first. It is followed by an enable edge, which is either a start or a controller reset. The result is reflected in a read-only status word with a ready bit, a fatal bit and a two-bit shutdown progress field.

Actions toward the core are one-cycle request pulses. A start request finishes on an acknowledge with a fail flag. A shutdown request finishes on a done input. While a sequence is in progress the block lowers its write-ready output, so no further register write is taken until it finishes. A reset caused by clearing the enable bit clears the configuration word, the status word and both interrupt mask words. In virtual-function mode the reset only rewrites the status word, according to whether the secondary controller is online.

Top module: `ctrl_cfg_regs`

## Requirements
- R1: Register offsets are configuration 0x0, status 0x4, mask-set 0x8 and mask-clear 0xC. `rd_data` shows the word at `req_addr` combinationally. After reset all four words read 0.
- R2: A write to the configuration word is stored in full (all 32 bits) before any edge action, and reads back unchanged unless the same write clears the enable bit outside virtual-function mode.
- R3: The status word is read-only. A write to offset 0x4 leaves its value unchanged.
- R4: `req_ready` is low from the cycle after a configuration write is accepted until its sequence has finished. Writes are taken only while it is high.
- R5: When the shutdown field (bits 15:14) changes from 0 to nonzero, exactly one `shdn_req` pulse is issued. Once `shdn_done` arrives, status bits 3:2 read 2'b10.
- R6: When the shutdown field changes from nonzero to 0, status bits 3:2 are cleared to 2'b00 and no `shdn_req` is issued.
- R7: Within one write, the shutdown action is carried out before the enable action: `shdn_req` comes before `start_req` or `ctrl_reset`.
- R8: When the enable bit (bit 0) rises, exactly one `start_req` pulse is issued. An acknowledge with `start_fail` low sets status bit 0 (ready) and leaves the other status bits alone. An acknowledge with `start_fail` high sets the status word to 0x2 (fatal bit 1 only).
- R9: When the enable bit falls and `vf_mode` is 0, one `ctrl_reset` pulse is issued. The configuration, status, mask-set and mask-clear words all become 0, and no other status update is made for that write.
- R10: When the enable bit falls and `vf_mode` is 1, one `ctrl_reset` pulse is issued. The status word becomes 0 if `sec_online` is 1 and 0x2 otherwise. The configuration and mask words keep their values.
- R11: A configuration write that changes neither the enable bit nor whether the shutdown field is zero leaves the status word unchanged and issues no request or reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vf_mode | input | 1 | Controller is a virtual function |
| sec_online | input | 1 | Secondary controller is online (used in virtual-function mode) |
| req_valid | input | 1 | Register access valid |
| req_write | input | 1 | Access is a write |
| req_addr | input | ADDR_W | Register byte offset |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Block can accept a write |
| rd_data | output | DW | Read data for `req_addr` |
| start_req | output | 1 | One-cycle controller start request |
| start_ack | input | 1 | Start finished |
| start_fail | input | 1 | Start failed, valid with `start_ack` |
| shdn_req | output | 1 | One-cycle shutdown request |
| shdn_done | input | 1 | Shutdown finished |
| ctrl_reset | output | 1 | One-cycle controller reset pulse |

## Verification
A wrong sequencer state shows at the ports as a missing, doubled or reordered request pulse in the few cycles after a configuration write. It can also show as `req_ready` staying low, which stalls every later write. Wrong edge capture or a wrong status update is visible in the status word as soon as the sequence finishes. The wrong value is a ready bit stuck at 0 after a good start, a stale shutdown field, or a fatal value where none belongs. A missed reset branch leaves nonzero configuration or mask words that a single read exposes.

// File: rtl/ccr_pkg.sv
// Package ccr_pkg: shared field positions, codes and sequencer states for
// the enable/shutdown register block. Assumes a 32-bit or wider data word.
package ccr_pkg;
    localparam int CFG_EN_BIT    = 0;
    localparam int CFG_SHN_LO    = 14;
    localparam int STS_RDY_BIT   = 0;
    localparam int STS_FATAL_BIT = 1;
    localparam int STS_SHST_LO   = 2;
    localparam logic [1:0] SHST_COMPLETE = 2'b10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SH,
        S_SH_WAIT,
        S_EN,
        S_ST_WAIT
    } seq_state_t;
endpackage

// File: rtl/ccr_edge.sv
// Module ccr_edge: compares the previous and the newly written enable bit and
// shutdown field and reports each edge. Purely combinational.
module ccr_edge (
    input  logic       old_en,
    input  logic       new_en,
    input  logic [1:0] old_shn,
    input  logic [1:0] new_shn,
    output logic       sh_rise,
    output logic       sh_fall,
    output logic       en_rise,
    output logic       en_fall
);
    // Edge classification of the two control fields.
    always_comb begin
        sh_rise = (old_shn == 2'b00) && (new_shn != 2'b00);
        sh_fall = (old_shn != 2'b00) && (new_shn == 2'b00);
        en_rise = !old_en && new_en;
        en_fall = old_en && !new_en;
    end
endmodule

// File: rtl/ccr_seq.sv
// Module ccr_seq: runs the actions of one configuration write in order:
// the shutdown edge first, then the enable edge. It issues one-cycle requests
// and waits for the core's completion inputs. Assumes go is only
// asserted while idle is high.
module ccr_seq
    import ccr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic sh_rise,
    input  logic sh_fall,
    input  logic en_rise,
    input  logic en_fall,
    input  logic shdn_done,
    input  logic start_ack,
    input  logic start_fail,
    output logic idle,
    output logic shdn_req,
    output logic start_req,
    output logic reset_pulse,
    output logic shst_done,
    output logic shst_clr,
    output logic rdy_set,
    output logic fatal_set
);
    seq_state_t st;
    logic f_shr, f_shf, f_enr, f_enf;

    // State register and captured edge flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            f_shr <= 1'b0;
            f_shf <= 1'b0;
            f_enr <= 1'b0;
            f_enf <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (go) begin
                        f_shr <= sh_rise;
                        f_shf <= sh_fall;
                        f_enr <= en_rise;
                        f_enf <= en_fall;
                        st    <= S_SH;
                    end
                end
                S_SH:      st <= f_shr ? S_SH_WAIT : S_EN;
                S_SH_WAIT: if (shdn_done) st <= S_EN;
                S_EN:      st <= f_enr ? S_ST_WAIT : S_IDLE;
                S_ST_WAIT: if (start_ack) st <= S_IDLE;
                default:   st <= S_IDLE;
            endcase
        end
    end

    // Request pulses and status update strobes decoded from the state.
    always_comb begin
        idle        = (st == S_IDLE);
        shdn_req    = (st == S_SH) && f_shr;
        shst_clr    = (st == S_SH) && f_shf;
        shst_done   = (st == S_SH_WAIT) && shdn_done;
        start_req   = (st == S_EN) && f_enr;
        reset_pulse = (st == S_EN) && f_enf;
        rdy_set     = (st == S_ST_WAIT) && start_ack && !start_fail;
        fatal_set   = (st == S_ST_WAIT) && start_ack && start_fail;
    end
endmodule

// File: rtl/ctrl_cfg_regs.sv
// Module ctrl_cfg_regs: configuration, status and interrupt mask registers of
// a storage host controller with enable/shutdown sequencing. It stores each
// configuration write, then lets ccr_seq act on the field edges. Assumes
// DW >= 16 and ADDR_W >= 4.
module ctrl_cfg_regs
    import ccr_pkg::*;
#(
    parameter int DW     = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vf_mode,
    input  logic              sec_online,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    output logic [DW-1:0]     rd_data,
    output logic              start_req,
    input  logic              start_ack,
    input  logic              start_fail,
    output logic              shdn_req,
    input  logic              shdn_done,
    output logic              ctrl_reset
);
    localparam int NMASK = 2;
    localparam logic [ADDR_W-1:0] OFF_CFG  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_STS  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(8);
    localparam logic [DW-1:0] FATAL_VAL = DW'(1) << STS_FATAL_BIT;

    logic [DW-1:0] cfg_q, sts_q;
    logic [DW-1:0] mask_q [NMASK];
    logic wr_acc, cfg_wr, idle;
    logic sh_rise, sh_fall, en_rise, en_fall;
    logic reset_pulse, shst_done, shst_clr, rdy_set, fatal_set;
    logic full_clear;

    // Write acceptance and the kind of reset in effect.
    always_comb begin
        wr_acc     = req_valid && req_write && idle;
        cfg_wr     = wr_acc && (req_addr == OFF_CFG);
        full_clear = reset_pulse && !vf_mode;
        req_ready  = idle;
        ctrl_reset = reset_pulse;
    end

    ccr_edge u_edge (
        .old_en  (cfg_q[CFG_EN_BIT]),
        .new_en  (req_wdata[CFG_EN_BIT]),
        .old_shn (cfg_q[CFG_SHN_LO +: 2]),
        .new_shn (req_wdata[CFG_SHN_LO +: 2]),
        .sh_rise (sh_rise),
        .sh_fall (sh_fall),
        .en_rise (en_rise),
        .en_fall (en_fall)
    );

    ccr_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (cfg_wr),
        .sh_rise     (sh_rise),
        .sh_fall     (sh_fall),
        .en_rise     (en_rise),
        .en_fall     (en_fall),
        .shdn_done   (shdn_done),
        .start_ack   (start_ack),
        .start_fail  (start_fail),
        .idle        (idle),
        .shdn_req    (shdn_req),
        .start_req   (start_req),
        .reset_pulse (reset_pulse),
        .shst_done   (shst_done),
        .shst_clr    (shst_clr),
        .rdy_set     (rdy_set),
        .fatal_set   (fatal_set)
    );

    // Configuration and status registers with their update priorities.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            sts_q <= '0;
        end else if (reset_pulse) begin
            if (vf_mode) begin
                sts_q <= sec_online ? '0 : FATAL_VAL;
            end else begin
                cfg_q <= '0;
                sts_q <= '0;
            end
        end else begin
            if (cfg_wr) cfg_q <= req_wdata;
            if (fatal_set)      sts_q <= FATAL_VAL;
            else if (rdy_set)   sts_q[STS_RDY_BIT] <= 1'b1;
            else if (shst_done) sts_q[STS_SHST_LO +: 2] <= SHST_COMPLETE;
            else if (shst_clr)  sts_q[STS_SHST_LO +: 2] <= 2'b00;
        end
    end

    // Interrupt mask set and clear words, one register per generated slot.
    for (genvar g = 0; g < NMASK; g++) begin : g_mask
        localparam logic [ADDR_W-1:0] OFF = OFF_MASK + ADDR_W'(4 * g);
        always_ff @(posedge clk) begin
            if (!rst_n || full_clear) mask_q[g] <= '0;
            else if (wr_acc && req_addr == OFF) mask_q[g] <= req_wdata;
        end
    end

    // Read multiplexer on the current offset.
    always_comb begin
        rd_data = '0;
        if (req_addr == OFF_CFG) rd_data = cfg_q;
        if (req_addr == OFF_STS) rd_data = sts_q;
        for (int i = 0; i < NMASK; i++) begin
            if (req_addr == OFF_MASK + ADDR_W'(4 * i)) rd_data = mask_q[i];
        end
    end
endmodule

// File: rtl/ccr_checker.sv
// Module ccr_checker: temporal properties of ctrl_cfg_regs. It tracks which
// request is outstanding on its own and is bound to every instance of the top.
module ccr_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          start_req,
    input logic          start_ack,
    input logic          start_fail,
    input logic          shdn_req,
    input logic          shdn_done,
    input logic          ctrl_reset,
    input logic          vf_mode,
    input logic          sec_online,
    input logic [DW-1:0] cfg_q,
    input logic [DW-1:0] sts_q
);
    logic st_pend, sh_pend;

    // Outstanding start and shutdown requests as seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_pend <= 1'b0;
            sh_pend <= 1'b0;
        end else begin
            if (start_req) st_pend <= 1'b1;
            else if (start_ack) st_pend <= 1'b0;
            if (shdn_req) sh_pend <= 1'b1;
            else if (shdn_done) sh_pend <= 1'b0;
        end
    end

    assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_pend |-> !req_ready);
    assert_busy_shdn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_pend |-> !req_ready);
    assert_shdn_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_req |=> !shdn_req);
    assert_shdn_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_pend && shdn_done) |=> (sts_q[3:2] == 2'b10));
    assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req || ctrl_reset) |-> !sh_pend);
    assert_start_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_pend && start_ack && !start_fail) |=> sts_q[0]);
    assert_start_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_pend && start_ack && start_fail) |=> (sts_q == DW'(2)));
    assert_full_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_reset && !vf_mode) |=> (cfg_q == '0 && sts_q == '0));
    assert_vf_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_reset && vf_mode) |=> (sts_q == ($past(sec_online) ? DW'(0) : DW'(2))));
endmodule

bind ctrl_cfg_regs ccr_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .start_req  (start_req),
    .start_ack  (start_ack),
    .start_fail (start_fail),
    .shdn_req   (shdn_req),
    .shdn_done  (shdn_done),
    .ctrl_reset (ctrl_reset),
    .vf_mode    (vf_mode),
    .sec_online (sec_online),
    .cfg_q      (cfg_q),
    .sts_q      (sts_q)
);

// File: tb/ctrl_cfg_regs_test.sv
// Bench ctrl_cfg_regs_test: sweeps every old/new pair of enable and shutdown
// settings across fail, virtual-function and online choices. A model of the
// core answers requests, and the bench checks the registers and pulses.
module ctrl_cfg_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 2;
    localparam logic [3:0] A_CFG = 4'h0, A_STS = 4'h4, A_MSET = 4'h8, A_MCLR = 4'hC;
    localparam logic [31:0] PAT_OLD = 32'h5A00_0210;
    localparam logic [31:0] PAT_NEW = 32'h00C3_1020;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vf_mode = 1'b0, sec_online = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [3:0] req_addr = 4'h0;
    logic [31:0] req_wdata = '0;
    logic req_ready;
    logic [31:0] rd_data;
    logic start_req, shdn_req, ctrl_reset;
    logic start_ack = 1'b0, start_fail = 1'b0, shdn_done = 1'b0;

    int checks = 0, errors = 0;
    bit finished = 0;
    int cyc = 0, n_sh = 0, n_st = 0, n_rs = 0, sh_at = 0, st_at = 0, rs_at = 0;
    int st_cnt = 0, sh_cnt = 0;

    ctrl_cfg_regs #(.DW(32), .ADDR_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .vf_mode(vf_mode), .sec_online(sec_online),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rd_data(rd_data),
        .start_req(start_req), .start_ack(start_ack), .start_fail(start_fail),
        .shdn_req(shdn_req), .shdn_done(shdn_done), .ctrl_reset(ctrl_reset)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Pulse counters sampled at the active edge.
    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            if (shdn_req)   begin n_sh++; sh_at = cyc; end
            if (start_req)  begin n_st++; st_at = cyc; end
            if (ctrl_reset) begin n_rs++; rs_at = cyc; end
        end
    end

    // Core model: answers each request LAT falling edges later.
    always @(negedge clk) begin
        start_ack = 1'b0;
        shdn_done = 1'b0;
        if (st_cnt > 0) begin st_cnt--; if (st_cnt == 0) start_ack = 1'b1; end
        if (sh_cnt > 0) begin sh_cnt--; if (sh_cnt == 0) shdn_done = 1'b1; end
        if (start_req) st_cnt = LAT;
        if (shdn_req)  sh_cnt = LAT;
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        st_cnt = 0;
        sh_cnt = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d, output logic rdy_after);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rdy_after = req_ready;
        while (!req_ready) @(negedge clk);
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        req_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [31:0] enc(input int v, input logic [31:0] pat);
        return pat | (32'((v >> 1) & 3) << 14) | 32'(v & 1);
    endfunction

    initial begin
        logic [31:0] rv, sts0, exp_sts, exp_cfg, exp_m, d_new;
        logic rdy;
        int b_sh, b_st, b_rs;
        string tg;

        do_reset();
        bus_read(A_CFG, rv);  check("R1 cfg reset", rv, 32'h0);
        bus_read(A_STS, rv);  check("R1 sts reset", rv, 32'h0);
        bus_read(A_MSET, rv); check("R1 mset reset", rv, 32'h0);
        bus_read(A_MCLR, rv); check("R1 mclr reset", rv, 32'h0);

        bus_write(A_CFG, 32'h0000_4001, rdy);
        bus_read(A_STS, sts0);
        check("R8 ready with shutdown done", sts0, 32'h9);
        bus_write(A_STS, 32'hFFFF_FFF2, rdy);
        bus_read(A_STS, rv); check("R3 status write ignored", rv, sts0);

        for (int vf = 0; vf < 2; vf++)
        for (int on = 0; on < 2; on++)
        for (int fl = 0; fl < 2; fl++)
        for (int ov = 0; ov < 8; ov++)
        for (int nv = 0; nv < 8; nv++) begin
            bit oen, nen, shr, shf, enr, enf;
            vf_mode = vf[0]; sec_online = on[0]; start_fail = 1'b0;
            do_reset();
            bus_write(A_CFG, enc(ov, PAT_OLD), rdy);
            bus_write(A_MSET, 32'h0000_00A5, rdy);
            bus_write(A_MCLR, 32'h0000_005A, rdy);
            bus_read(A_STS, sts0);
            b_sh = n_sh; b_st = n_st; b_rs = n_rs;
            start_fail = fl[0];
            d_new = enc(nv, PAT_NEW);
            bus_write(A_CFG, d_new, rdy);
            check("R4 ready low after config write", 32'(rdy), 32'h0);

            oen = ov[0]; nen = nv[0];
            shr = (ov >> 1) == 0 && (nv >> 1) != 0;
            shf = (ov >> 1) != 0 && (nv >> 1) == 0;
            enr = !oen && nen;
            enf = oen && !nen;
            exp_sts = sts0;
            if (shr) exp_sts[3:2] = 2'b10;
            if (shf) exp_sts[3:2] = 2'b00;
            if (enr) exp_sts = fl ? 32'h2 : (exp_sts | 32'h1);
            if (enf) exp_sts = vf ? (on ? 32'h0 : 32'h2) : 32'h0;
            exp_cfg = (enf && vf == 0) ? 32'h0 : d_new;
            exp_m = (enf && vf == 0) ? 32'h0 : 32'hA5;
            tg = enf ? (vf ? "R10 status" : "R9 status") : enr ? "R8 status" :
                 shr ? "R5 status" : shf ? "R6 status" : "R11 status";

            bus_read(A_STS, rv);  check(tg, rv, exp_sts);
            bus_read(A_CFG, rv);  check(enf ? "R9 R10 cfg" : "R2 cfg stored", rv, exp_cfg);
            bus_read(A_MSET, rv); check("R9 R10 mset", rv, exp_m);
            bus_read(A_MCLR, rv); check("R9 R10 mclr", rv, exp_m == 0 ? 32'h0 : 32'h5A);
            check("R5 R6 R11 shutdown pulses", 32'(n_sh - b_sh), 32'(shr));
            check("R8 R11 start pulses", 32'(n_st - b_st), 32'(enr));
            check("R9 R10 R11 reset pulses", 32'(n_rs - b_rs), 32'(enf));
            if (shr && enr) check("R7 shutdown before start", 32'(sh_at < st_at), 32'h1);
            if (shr && enf) check("R7 shutdown before reset", 32'(sh_at < rs_at), 32'h1);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule